// File: doc/BRIEF.md
# Posted-Write Socket Slave with Register Memory

This block is the target end of a point-to-point, synchronous core socket. It sits in front of a small word-addressed register memory. A master drives a 3-bit command with an address, and with write data when the data phase is not split. The slave takes a request by raising its command-accept in the cycle the request is presented. Reads are answered later on a separate response channel that carries a 3-bit response code and data. Writes are posted: they finish when accepted and never produce a response.

With the split data phase enabled (parameter `SPLIT_WD = 1`, the default), write data travels on its own valid/accept pair after the request. The memory is written only once both halves of the write have been taken. Read responses go through a small in-order queue. The master drains it with its own response-accept.

Top module: `sock_slave`

## Requirements
- R1: After reset, command-accept and write-data-accept are low, the response code is 000 (none), and every memory word reads back as zero.
- R2: Command code 001 is a write and 010 is a read. Code 000 and every other value (011, 1xx) are idle: the slave does not accept them and they change no memory word.
- R3: A write request is accepted in the same cycle it is presented when no earlier write is waiting for data. It produces no response, and the memory word changes only once its data has been accepted on the write-data pair.
- R4: A read is accepted in the same cycle it is presented when the queue has room and no write is waiting for data. Its response (code 001, the addressed word) appears at the queue head on the next cycle when the queue was empty.
- R5: A read of an address at or above 32 gets response code 011 with zero data. A write to such an address is accepted but changes no memory word.
- R6: Up to 4 read responses are held and returned in request order. While 4 are held, a presented read is not accepted.
- R7: A response at the queue head stays unchanged until the master raises response-accept. The head then advances one entry per accepting cycle, and the code returns to 000 when the queue is empty.
- R8: Write-data-valid is accepted only while a write request is waiting for its data. At any other time it is ignored.
- R9: While a write request waits for its data, no new request of either kind is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every signal |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cmd | input | 3 | Request command: 000 idle, 001 write, 010 read |
| m_addr | input | AW (8) | Word address of the request |
| m_wdata | input | DW (32) | Write data carried with the request (unsplit mode only) |
| s_cmd_acc | output | 1 | Request accepted this cycle |
| m_wd_valid | input | 1 | Write data valid on the separate data pair |
| m_wd_data | input | DW (32) | Write data on the separate data pair |
| s_wd_acc | output | 1 | Write data accepted this cycle |
| s_resp | output | 3 | Response code: 000 none, 001 data valid, 011 error |
| s_rdata | output | DW (32) | Read data belonging to the response |
| m_resp_acc | input | 1 | Master takes the head response this cycle |

## Verification
The hardest state to reach from the ports is a full response queue with a fifth read pending. This is also where a write is still waiting for its data and a read is presented behind it. The bench reaches the first by holding response-accept low while it issues four reads to preloaded, distinct words. It then presents a fifth read and checks that the head stays frozen, before it drains in order. It reaches the second by accepting a write request, delaying its data for several cycles and presenting a read of the same word meanwhile. The read must be refused until the data arrives, and it must then return the new value.

// File: rtl/sock_slave.sv
module sock_slave #(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int DEPTH    = 32,
  parameter int QDEPTH   = 4,
  parameter bit SPLIT_WD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    m_cmd,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic          s_cmd_acc,
  input  logic          m_wd_valid,
  input  logic [DW-1:0] m_wd_data,
  output logic          s_wd_acc,
  output logic [2:0]    s_resp,
  output logic [DW-1:0] s_rdata,
  input  logic          m_resp_acc
);
  localparam int IW = $clog2(DEPTH);
  localparam int QW = $clog2(QDEPTH);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [2:0] RSP_NONE = 3'b000;
  localparam logic [2:0] RSP_DVA  = 3'b001;
  localparam logic [2:0] RSP_ERR  = 3'b011;

  logic [DW-1:0] mem [DEPTH];
  logic [2:0]    q_code [QDEPTH];
  logic [DW-1:0] q_data [QDEPTH];
  logic [QW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          pend_vld, pend_in;
  logic [IW-1:0] pend_idx;

  wire is_wr  = (m_cmd == 3'b001);
  wire is_rd  = (m_cmd == 3'b010);
  wire in_rng = (int'(m_addr) < DEPTH);
  wire q_full = (cnt == CW'(QDEPTH));
  wire q_nemp = (cnt != '0);
  wire pop    = m_resp_acc & q_nemp;

  assign s_cmd_acc = ~pend_vld & (is_wr | (is_rd & ~q_full));
  wire wr_acc = s_cmd_acc & is_wr;
  wire rd_acc = s_cmd_acc & is_rd;

  logic          cm_en;
  logic [IW-1:0] cm_idx;
  logic [DW-1:0] cm_dat;

  generate
    if (SPLIT_WD) begin : g_split
      assign s_wd_acc = pend_vld & m_wd_valid;
      assign cm_en    = s_wd_acc & pend_in;
      assign cm_idx   = pend_idx;
      assign cm_dat   = m_wd_data;
    end else begin : g_joint
      assign s_wd_acc = 1'b0;
      assign cm_en    = wr_acc & in_rng;
      assign cm_idx   = m_addr[IW-1:0];
      assign cm_dat   = m_wdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_in  <= 1'b0;
      pend_idx <= '0;
    end else if (SPLIT_WD) begin
      if (wr_acc) begin
        pend_vld <= 1'b1;
        pend_in  <= in_rng;
        pend_idx <= m_addr[IW-1:0];
      end else if (s_wd_acc) begin
        pend_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cm_en) begin
      mem[cm_idx] <= cm_dat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_code[i] <= RSP_NONE;
        q_data[i] <= '0;
      end
    end else begin
      if (rd_acc) begin
        q_code[wptr] <= in_rng ? RSP_DVA : RSP_ERR;
        q_data[wptr] <= in_rng ? mem[m_addr[IW-1:0]] : '0;
        wptr         <= wptr + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(rd_acc) - CW'(pop);
    end
  end

  assign s_resp  = q_nemp ? q_code[rptr] : RSP_NONE;
  assign s_rdata = q_nemp ? q_data[rptr] : '0;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(QDEPTH));
  p_push_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !pop) |=> (cnt == CW'($past(cnt) + 1'b1)));
  p_resp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_resp != RSP_NONE && !m_resp_acc) |=> ($stable(s_resp) && $stable(s_rdata)));
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !s_wd_acc) |=> (pend_vld && !s_cmd_acc));
  p_pend_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_vld) |-> $past(wr_acc));
endmodule

// File: tb/sock_slave_tb_top.sv
module sock_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  m_cmd = 3'b000;
  logic [7:0]  m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic        s_cmd_acc;
  logic        m_wd_valid = 1'b0;
  logic [31:0] m_wd_data = '0;
  logic        s_wd_acc;
  logic [2:0]  s_resp;
  logic [31:0] s_rdata;
  logic        m_resp_acc = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  sock_slave dut_i (
    .clk(clk), .rst_n(rst_n), .m_cmd(m_cmd), .m_addr(m_addr), .m_wdata(m_wdata),
    .s_cmd_acc(s_cmd_acc), .m_wd_valid(m_wd_valid), .m_wd_data(m_wd_data),
    .s_wd_acc(s_wd_acc), .s_resp(s_resp), .s_rdata(s_rdata), .m_resp_acc(m_resp_acc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_req(input logic [7:0] a);
    @(negedge clk);
    m_cmd = 3'b001; m_addr = a;
    #1 chk("R3 write accepted", 32'(s_cmd_acc), 1);
    @(posedge clk);
    @(negedge clk);
    m_cmd = 3'b000;
    chk("R3 no response to write", 32'(s_resp), 0);
  endtask

  task automatic wr_dat(input logic [31:0] d);
    m_wd_valid = 1'b1; m_wd_data = d;
    #1 chk("R8 data accepted while pending", 32'(s_wd_acc), 1);
    @(posedge clk);
    @(negedge clk);
    m_wd_valid = 1'b0;
  endtask

  task automatic write_word(input logic [7:0] a, input logic [31:0] d);
    wr_req(a);
    wr_dat(d);
  endtask

  task automatic read_word(input string req, input logic [7:0] a,
                           input logic [2:0] ec, input logic [31:0] ed);
    @(negedge clk);
    m_cmd = 3'b010; m_addr = a;
    #1 chk({req, " R4 read accepted"}, 32'(s_cmd_acc), 1);
    @(posedge clk);
    @(negedge clk);
    m_cmd = 3'b000;
    chk({req, " R4 code"}, 32'(s_resp), 32'(ec));
    chk({req, " R4 data"}, s_rdata, ed);
    m_resp_acc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_resp_acc = 1'b0;
    chk({req, " R7 empty after take"}, 32'(s_resp), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    m_wd_valid = 1'b1;
    #1 chk("R1 cmd_acc idle", 32'(s_cmd_acc), 0);
    chk("R1 R8 wd_acc without pending write", 32'(s_wd_acc), 0);
    chk("R1 resp none", 32'(s_resp), 0);
    m_wd_valid = 1'b0;
    read_word("R1 reset memory", 8'd5, 3'b001, 32'h0);
  endtask

  task automatic t_write_read;
    write_word(8'd3, 32'hA5A5_0003);
    read_word("R3 basic", 8'd3, 3'b001, 32'hA5A5_0003);
    write_word(8'd31, 32'h1234_5678);
    read_word("R3 top word", 8'd31, 3'b001, 32'h1234_5678);
  endtask

  task automatic t_late_data;
    write_word(8'd7, 32'h0000_0077);
    wr_req(8'd7);
    m_cmd = 3'b010; m_addr = 8'd7;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R9 read held off while write waits", 32'(s_cmd_acc), 0);
      @(posedge clk);
      @(negedge clk);
    end
    m_cmd = 3'b000;
    wr_dat(32'hDEAD_0007);
    read_word("R3 commit after data", 8'd7, 3'b001, 32'hDEAD_0007);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    m_addr = 8'd3; m_wdata = 32'hBAD0_BAD0; m_wd_valid = 1'b1; m_wd_data = 32'hBAD1_BAD1;
    for (int c = 3; c < 8; c++) begin
      m_cmd = 3'(c);
      #1 chk("R2 reserved code not accepted", 32'(s_cmd_acc), 0);
      chk("R2 R8 no data accept", 32'(s_wd_acc), 0);
      @(posedge clk);
      @(negedge clk);
    end
    m_cmd = 3'b000; m_wd_valid = 1'b0;
    read_word("R2 word unchanged", 8'd3, 3'b001, 32'hA5A5_0003);
  endtask

  task automatic t_range;
    read_word("R5 out of range", 8'd40, 3'b011, 32'h0);
    write_word(8'd40, 32'hFFFF_0040);
    read_word("R5 no alias write", 8'd8, 3'b001, 32'h0);
    read_word("R5 top address", 8'd255, 3'b011, 32'h0);
  endtask

  task automatic t_queue;
    for (int i = 0; i < 4; i++) write_word(8'(10 + i), 32'hC0DE_0000 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      m_cmd = 3'b010; m_addr = 8'(10 + i);
      #1 chk("R6 queued read accepted", 32'(s_cmd_acc), 1);
      @(posedge clk);
    end
    @(negedge clk);
    m_addr = 8'd2;
    for (int i = 0; i < 2; i++) begin
      #1 chk("R6 fifth read refused when full", 32'(s_cmd_acc), 0);
      chk("R7 head held", s_rdata, 32'hC0DE_0000);
      @(posedge clk);
      @(negedge clk);
    end
    m_cmd = 3'b000;
    for (int i = 0; i < 4; i++) begin
      chk("R6 in-order code", 32'(s_resp), 1);
      chk("R6 in-order data", s_rdata, 32'hC0DE_0000 + 32'(i));
      m_resp_acc = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    m_resp_acc = 1'b0;
    chk("R7 none when drained", 32'(s_resp), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_late_data();
    t_illegal();
    t_range();
    t_queue();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule